// File: doc/BRIEF.md
# Write-Recovery Precharge Guard

This block sits inside the command scheduler of a DDR2 memory controller and decides, bank by bank, when a PRECHARGE may be issued after a write. It watches every command the scheduler issues. On a WRITE it works out when the last data pair of that burst will be on the bus. It assumes the write strobe arrives at the late end of its skew window. From that point it applies the programmed write-recovery time before the bank may be closed.

The scheduler reads one precharge-allowed flag per bank and holds back any PRECHARGE whose flag is low. An all-bank PRECHARGE needs every flag to be high. If a PRECHARGE is issued too early anyway, the guard raises a one-cycle error pulse and leaves its timing state untouched. The write latency, burst length and recovery time are taken from configuration inputs at the moment of each WRITE.

Top module: `wr_pre_guard`

## Requirements
- R1: While reset is held and after it is released, every bit of `pre_ok_o` is 1 and `err_o` is 0.
- R2: A WRITE (`cmd_valid_i`=1, `cmd_type_i`=2'b01) sampled at edge e0 clears `pre_ok_o[bank_i]` after e0. The flags of other banks are unaffected.
- R3: Write latency WL is AL+CL-1. The burst occupies BL/2 clocks, with BL=8 when `bl8_i`=1 and BL=4 otherwise. For a write at edge e0, the first edge at which a same-bank PRECHARGE is legal is e0+WL+BL/2+1+tWR. The +1 is the first rising edge after the late last data pair. `pre_ok_o[b]` rises right after the edge before that one.
- R4: A single-bank PRECHARGE (`cmd_type_i`=2'b10, `a10_i`=0) sampled while the target bank's flag is low sets `err_o` for exactly the one cycle after that edge. The bank's timing is not changed.
- R5: A single-bank PRECHARGE to a bank whose flag is high gives no error, even while other banks are still recovering.
- R6: An all-bank PRECHARGE (`cmd_type_i`=2'b10, `a10_i`=1) raises `err_o` for one cycle if any flag is low, and otherwise does not.
- R7: A WRITE to a bank that is still recovering restarts its window from the new write's own timing.
- R8: Commands with `cmd_valid_i`=0, and command types 2'b00 and 2'b11, change no flag and raise no error.
- R9: The value of `a10_i` on a WRITE does not change that write's recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A command is issued this cycle |
| cmd_type_i | input | 2 | 01 write, 10 precharge, others ignored |
| bank_i | input | BANK_W | Target bank address |
| a10_i | input | 1 | Auto-precharge bit on write; all-bank select on precharge |
| al_i | input | AL_W | Additive latency in clocks |
| cl_i | input | CL_W | CAS latency in clocks |
| bl8_i | input | 1 | Burst length 8 when set, 4 when clear |
| twr_i | input | TWR_W | Write-recovery time in clocks |
| pre_ok_o | output | NUM_BANKS | Per-bank precharge-allowed flags |
| err_o | output | 1 | One-cycle pulse after an early precharge |

## Verification
The checker watches several rules on every cycle. Every WRITE must pull its bank's flag low. A single-bank or all-bank PRECHARGE that meets a low flag must produce an error pulse. A legal one must not. An error may only follow a PRECHARGE, and a flag may only fall after a write. The exact length of each recovery window cannot be checked that way, since it depends on AL, CL, burst length and tWR. Only the bench's scenarios show that length, along with the restart of a window on a rewrite and the freedom of A10 on a WRITE. The bench's timed model predicts the legal edge for each of these.

// File: rtl/wpg_pkg.sv
`timescale 1ns/1ps
package wpg_pkg;
  typedef enum logic [1:0] {
    CMD_OTHER0 = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_PRE    = 2'b10,
    CMD_OTHER3 = 2'b11
  } cmd_e;
endpackage

// File: rtl/wpg_cmd_decode.sv
`timescale 1ns/1ps
module wpg_cmd_decode
  import wpg_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 cmd_valid_i,
  input  logic [1:0]           cmd_type_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 a10_i,
  output logic [NUM_BANKS-1:0] wr_hit_o,
  output logic                 pre_one_o,
  output logic                 pre_all_o
);
  logic is_wr, is_pre;

  assign is_wr     = cmd_valid_i && (cmd_e'(cmd_type_i) == CMD_WRITE);
  assign is_pre    = cmd_valid_i && (cmd_e'(cmd_type_i) == CMD_PRE);
  assign pre_one_o = is_pre && !a10_i;
  assign pre_all_o = is_pre && a10_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign wr_hit_o[b] = is_wr && (bank_i == BANK_W'(b));
  end
endmodule

// File: rtl/wpg_load_calc.sv
`timescale 1ns/1ps
module wpg_load_calc #(
  parameter int AL_W  = 3,
  parameter int CL_W  = 3,
  parameter int TWR_W = 4,
  parameter int CNT_W = 6
) (
  input  logic [AL_W-1:0]  al_i,
  input  logic [CL_W-1:0]  cl_i,
  input  logic             bl8_i,
  input  logic [TWR_W-1:0] twr_i,
  output logic [CNT_W-1:0] load_o
);
  logic [CNT_W-1:0] lat_sum, wl, half_bl;

  assign lat_sum = CNT_W'(al_i) + CNT_W'(cl_i);
  assign wl      = (lat_sum == '0) ? '0 : lat_sum - CNT_W'(1);
  assign half_bl = bl8_i ? CNT_W'(4) : CNT_W'(2);
  // late DQSS pushes start to the next edge; counter zero means the following edge is legal
  assign load_o  = wl + half_bl + CNT_W'(twr_i);
endmodule

// File: rtl/wpg_bank_timer.sv
`timescale 1ns/1ps
module wpg_bank_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             ok_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign ok_o = (cnt_q == '0);
endmodule

// File: rtl/wr_pre_guard.sv
`timescale 1ns/1ps
module wr_pre_guard #(
  parameter int NUM_BANKS = 8,
  parameter int AL_W      = 3,
  parameter int CL_W      = 3,
  parameter int TWR_W     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2((1 << AL_W) + (1 << CL_W) + 4 + (1 << TWR_W))
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  input  logic [1:0]           cmd_type_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 a10_i,
  input  logic [AL_W-1:0]      al_i,
  input  logic [CL_W-1:0]      cl_i,
  input  logic                 bl8_i,
  input  logic [TWR_W-1:0]     twr_i,
  output logic [NUM_BANKS-1:0] pre_ok_o,
  output logic                 err_o
);
  logic [NUM_BANKS-1:0] wr_hit, ok;
  logic                 pre_one, pre_all;
  logic [CNT_W-1:0]     load_val;
  logic                 err_d, err_q;

  wpg_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_type_i  (cmd_type_i),
    .bank_i      (bank_i),
    .a10_i       (a10_i),
    .wr_hit_o    (wr_hit),
    .pre_one_o   (pre_one),
    .pre_all_o   (pre_all)
  );

  wpg_load_calc #(.AL_W(AL_W), .CL_W(CL_W), .TWR_W(TWR_W), .CNT_W(CNT_W)) u_calc (
    .al_i   (al_i),
    .cl_i   (cl_i),
    .bl8_i  (bl8_i),
    .twr_i  (twr_i),
    .load_o (load_val)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wpg_bank_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (wr_hit[b]),
      .load_val_i (load_val),
      .ok_o       (ok[b])
    );
  end

  always_comb begin
    err_d = 1'b0;
    if (pre_one)      err_d = !ok[bank_i];
    else if (pre_all) err_d = !(&ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign pre_ok_o = ok;
  assign err_o    = err_q;
endmodule

// File: rtl/wr_pre_guard_chk.sv
`timescale 1ns/1ps
module wr_pre_guard_chk #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_valid_i,
  input logic [1:0]           cmd_type_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic                 a10_i,
  input logic [NUM_BANKS-1:0] pre_ok_o,
  input logic                 err_o
);
  logic is_wr, is_pre;
  assign is_wr  = cmd_valid_i && cmd_type_i == 2'b01;
  assign is_pre = cmd_valid_i && cmd_type_i == 2'b10;

  // R2
  write_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wr |=> !pre_ok_o[$past(bank_i)]);

  // R4
  early_pre_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre && !a10_i && !pre_ok_o[bank_i]) |=> err_o);

  // R5
  legal_pre_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre && !a10_i && pre_ok_o[bank_i]) |=> !err_o);

  // R6
  all_pre_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre && a10_i) |=> (err_o == !(&$past(pre_ok_o))));

  // R8
  err_needs_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_pre |=> !err_o);

  // R8
  flag_fall_needs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_wr |=> (($past(pre_ok_o) & ~pre_ok_o) == '0));
endmodule

bind wr_pre_guard wr_pre_guard_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_type_i  (cmd_type_i),
  .bank_i      (bank_i),
  .a10_i       (a10_i),
  .pre_ok_o    (pre_ok_o),
  .err_o       (err_o)
);

// File: tb/wr_pre_guard_test.sv
`timescale 1ns/1ps
module wr_pre_guard_test;
  localparam int NB = 8;

  typedef struct {
    logic          err;
    logic [NB-1:0] ok;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_type = 2'b00;
  logic [2:0]    bank = '0;
  logic          a10 = 1'b0;
  logic [2:0]    al = 3'd0;
  logic [2:0]    cl = 3'd3;
  logic          bl8 = 1'b0;
  logic [3:0]    twr = 4'd3;
  logic [NB-1:0] pre_ok;
  logic          err;

  int   n_chk = 0, n_fail = 0, edges = 0;
  int   ready [NB];
  exp_t sb [$];
  bit   done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  wr_pre_guard #(.NUM_BANKS(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_type_i(cmd_type),
    .bank_i(bank), .a10_i(a10), .al_i(al), .cl_i(cl), .bl8_i(bl8), .twr_i(twr),
    .pre_ok_o(pre_ok), .err_o(err)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [NB-1:0] act_ok, exp_ok,
                       input logic act_err, exp_err);
    n_chk++;
    if (act_ok !== exp_ok || act_err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: ok=%b err=%b expected ok=%b err=%b", req, act_ok, act_err, exp_ok, exp_err);
    end
  endtask

  // driver: issue one command per cycle and queue the expected result
  task automatic step(input logic v, input logic [1:0] t, input int b, input logic a, input string req);
    exp_t e;
    int   k;
    @(negedge clk);
    cmd_valid = v; cmd_type = t; bank = 3'(b); a10 = a;
    k = edges + 1;  // edge that samples this command
    e.err = 1'b0;
    if (v && t == 2'b10) begin
      if (!a) e.err = (ready[b] > k);
      else for (int i = 0; i < NB; i++) if (ready[i] > k) e.err = 1'b1;
    end
    if (v && t == 2'b01)
      ready[b] = k + (int'(al) + int'(cl) - 1) + (bl8 ? 4 : 2) + 1 + int'(twr);
    for (int i = 0; i < NB; i++) e.ok[i] = (ready[i] <= k + 1);
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) step(1'b0, 2'b01, 0, 1'b0, req);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(e.req, pre_ok, e.ok, err, e.err);
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NB; i++) ready[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", pre_ok, '1, err, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", pre_ok, '1, err, 1'b0);

    // CL3 AL0 BL4 tWR3: legal at e0+8
    step(1, 2'b01, 2, 0, "R2 write bank2");
    step(1, 2'b10, 5, 0, "R5 other bank pre");
    step(1, 2'b10, 0, 1, "R6 all-bank early");
    step(1, 2'b10, 2, 0, "R4 early same-bank");
    for (int i = 0; i < 6; i++) step(1, 2'b10, 2, 0, "R3 R4 pre sweep bank2");
    step(1, 2'b10, 0, 1, "R6 all-bank legal");

    // R8 ignored commands
    step(0, 2'b01, 4, 0, "R8 invalid write");
    step(1, 2'b11, 4, 0, "R8 other type");
    step(1, 2'b00, 4, 1, "R8 other type a10");
    step(0, 2'b10, 4, 1, "R8 invalid pre");

    // R7 rewrite restarts window
    step(1, 2'b01, 1, 0, "R7 first write");
    idle(3, "R7 wait");
    step(1, 2'b01, 1, 0, "R7 rewrite");
    for (int i = 0; i < 10; i++) step(1, 2'b10, 1, 0, "R7 pre sweep bank1");

    // R9 a10 high on write, BL8 AL2 CL4 tWR5
    al = 3'd2; cl = 3'd4; bl8 = 1'b1; twr = 4'd5;
    step(1, 2'b01, 6, 1, "R9 write a10 high");
    step(1, 2'b01, 3, 0, "R3 write bank3 BL8");
    for (int i = 0; i < 16; i++) step(1, 2'b10, 6, 0, "R9 R3 pre sweep bank6");
    for (int i = 0; i < 3; i++) step(1, 2'b10, 3, 0, "R3 pre bank3");
    step(1, 2'b10, 0, 1, "R6 all-bank final");
    idle(3, "R8 drain");

    wait (sb.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule